// File: doc/BRIEF.md
# Byte Memory DMA Controller

This block moves words between a byte-wide external memory and on-chip program or data memory while the processor keeps running. A transfer reads or writes bytes one at a time on the external bus. Each byte becomes part of a word bound for internal memory, or is taken from a word fetched from it. Four packing formats are available. One builds 24-bit program words from three bytes. One builds 16-bit data words from two bytes. The other two place a single byte in the upper or the lower half of a data word.

Software programs the block through a small write port. The settings are the internal start address, a 14-bit external offset, an 8-bit page, a mode word (direction and format), a byte wait-state count and the word count. Writing a nonzero word count starts the transfer. The count then counts down as words complete and can be read back as progress. The external address is the page concatenated above the offset, and it advances one byte at a time across page boundaries. The processor has priority on the external bus: the block waits while the processor is using it. Each word occupies the internal memory port for exactly one cycle. A one-cycle interrupt pulse marks the end of the transfer.

Top module: `byteDmaEngine`

## Requirements
- R1: Bytes are handled most significant first, at rising byte addresses, and the mode field `cfgWrData[2:1]` selects the packing. Code 00 maps three bytes to word bits 23:16, 15:8, 7:0 and targets program memory (`memIsProg`=1). Code 01 maps two bytes to bits 15:8, 7:0. Code 10 maps one byte to bits 15:8. Code 11 maps one byte to bits 7:0. A store sends bytes taken from the same fields in the same order.
- R2: On a load in formats 01, 10 and 11, every word bit that no byte fills is written as zero.
- R3: `extAddr` is the page (bits 21:14) over the offset (bits 13:0). It starts at the programmed values and rises by one per byte. The offset carries into the page, and the page wraps from 255 to 0.
- R4: The first word uses the programmed internal address, and each later word uses the next higher address.
- R5: Writing select 5 with a nonzero value while idle starts a transfer: `busy` is high from the next cycle and `statCount` holds the value. The count drops by one after each word completes. A zero count write starts nothing.
- R6: Each byte access holds `extRd` or `extWr` with a steady address for (wait setting + 1) cycles. A load samples `extDataIn` in the last of these cycles.
- R7: After the final word, `statCount` reads 0, `busy` falls and `doneIrq` is high for exactly one cycle.
- R8: While `cpuExtAccess` is high, no new byte access begins; `extReq` stays high while the block waits for the bus.
- R9: A load uses one `memWrEn` cycle per word and a store uses one `memRdEn` cycle per word. Internal and external strobes never coincide.
- R10: Mode bit `cfgWrData[0]` selects direction: 0 loads from byte memory and 1 stores to it. `extDataOe` is high only during store accesses.
- R11: Configuration writes made while `busy` is high have no effect on the running transfer.
- R12: In reset and just after it, the block is idle: no strobes, `statCount` 0, `doneIrq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Setting select: 0 internal address, 1 offset, 2 page, 3 mode, 4 wait, 5 count |
| cfgWrData | input | 14 | Configuration write value |
| statCount | output | 14 | Words remaining |
| busy | output | 1 | Transfer in progress |
| doneIrq | output | 1 | One-cycle completion pulse |
| cpuExtAccess | input | 1 | Processor is using the external bus |
| extReq | output | 1 | Block wants or holds the external bus |
| extAddr | output | 22 | External byte address |
| extRd | output | 1 | External byte read strobe |
| extWr | output | 1 | External byte write strobe |
| extDataIn | input | 8 | Byte read from external memory |
| extDataOut | output | 8 | Byte written to external memory |
| extDataOe | output | 1 | Output enable for the external data pins |
| memAddr | output | 14 | Internal memory word address |
| memRdEn | output | 1 | Internal read strobe (data returns next cycle) |
| memWrEn | output | 1 | Internal write strobe |
| memIsProg | output | 1 | Internal access targets program memory |
| memWrData | output | 24 | Word written to internal memory |
| memRdData | input | 24 | Word read from internal memory |

## Verification
The hardest cases to reach are a setting write that lands in the middle of a transfer, and processor bus activity that arrives exactly while the block is waiting to start a byte. The bench drives pseudo-random processor traffic on every cycle and reads it back in the same phase as the design. Its reference model then tracks each extra arbitration cycle. In a dedicated run, writes to the count, page and wait settings are issued several cycles after the start. Page-crossing and full-address wrap runs begin a few bytes below each boundary.

// File: rtl/byteDmaPkg.sv
package byteDmaPkg;
  timeunit 1ns;
  timeprecision 10ps;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LATCH, ST_ARB, ST_ACCESS, ST_COMMIT
  } dmaStateT;

  typedef enum logic [1:0] {
    FMT_PROG24 = 2'b00,
    FMT_DATA16 = 2'b01,
    FMT_HIGH8  = 2'b10,
    FMT_LOW8   = 2'b11
  } byteFmtT;

  localparam logic [2:0] SEL_INTADDR = 3'd0;
  localparam logic [2:0] SEL_OFFSET  = 3'd1;
  localparam logic [2:0] SEL_PAGE    = 3'd2;
  localparam logic [2:0] SEL_MODE    = 3'd3;
  localparam logic [2:0] SEL_WAIT    = 3'd4;
  localparam logic [2:0] SEL_COUNT   = 3'd5;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic startXfer;
    logic clrShift;
    logic shiftIn;
    logic shiftOut;
    logic loadOut;
    logic incExt;
    logic incInt;
    logic decCount;
  } dmaCtlT;

  // Bytes per word, minus one
  function automatic logic [1:0] bytesLess1(input byteFmtT f);
    case (f)
      FMT_PROG24: return 2'd2;
      FMT_DATA16: return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/byteDmaData.sv
module byteDmaData
  import byteDmaPkg::*;
#(
  parameter int INT_AW = 14,
  parameter int OFF_W  = 14,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 14,
  parameter int WAIT_W = 3,
  parameter int CFG_W  = 14,
  localparam int EXT_W = OFF_W + PAGE_W,
  localparam int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              busy,
  input  dmaCtlT            ctl,
  input  logic [7:0]        extDataIn,
  input  logic [WORD_W-1:0] memRdData,
  output logic              startReq,
  output byteFmtT           fmt,
  output logic              dirStore,
  output logic [WAIT_W-1:0] waitCfg,
  output logic              lastWord,
  output logic [EXT_W-1:0]  extAddr,
  output logic [7:0]        extDataOut,
  output logic [INT_AW-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic [CNT_W-1:0]  statCount
);
  timeunit 1ns;
  timeprecision 10ps;

  logic [INT_AW-1:0] intAddr;
  logic [EXT_W-1:0]  extPtr;
  logic [CNT_W-1:0]  wordCnt;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] alignedRd;

  assign startReq = cfgWrEn && !busy && (cfgSel == SEL_COUNT) &&
                    (cfgWrData[CNT_W-1:0] != '0);

  // Settings and address counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intAddr  <= '0;
      extPtr   <= '0;
      fmt      <= FMT_PROG24;
      dirStore <= 1'b0;
      waitCfg  <= '0;
    end else begin
      if (cfgWrEn && !busy) begin
        case (cfgSel)
          SEL_INTADDR: intAddr <= cfgWrData[INT_AW-1:0];
          SEL_OFFSET:  extPtr[OFF_W-1:0] <= cfgWrData[OFF_W-1:0];
          SEL_PAGE:    extPtr[EXT_W-1:OFF_W] <= cfgWrData[PAGE_W-1:0];
          SEL_MODE: begin
            dirStore <= cfgWrData[0];
            fmt      <= byteFmtT'(cfgWrData[2:1]);
          end
          SEL_WAIT:    waitCfg <= cfgWrData[WAIT_W-1:0];
          default: ;
        endcase
      end
      if (ctl.incInt) intAddr <= intAddr + 1'b1;
      if (ctl.incExt) extPtr <= extPtr + 1'b1;
    end
  end

  // Word counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wordCnt <= '0;
    else if (ctl.startXfer) wordCnt <= cfgWrData[CNT_W-1:0];
    else if (ctl.decCount)  wordCnt <= wordCnt - 1'b1;
  end

  // Store: fetched word placed so the first byte to send sits on top
  always_comb begin
    case (fmt)
      FMT_PROG24: alignedRd = memRdData;
      FMT_DATA16: alignedRd = {memRdData[15:0], 8'h00};
      FMT_HIGH8:  alignedRd = {memRdData[15:8], 16'h0000};
      default:    alignedRd = {memRdData[7:0], 16'h0000};
    endcase
  end

  // Shared shift register: assembles on loads, drains on stores
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (ctl.clrShift) shiftReg <= '0;
    else if (ctl.loadOut)  shiftReg <= alignedRd;
    else if (ctl.shiftIn)  shiftReg <= {shiftReg[WORD_W-9:0], extDataIn};
    else if (ctl.shiftOut) shiftReg <= {shiftReg[WORD_W-9:0], 8'h00};
  end

  // Load: assembled bytes placed into the word fields of the format
  always_comb begin
    case (fmt)
      FMT_PROG24: memWrData = shiftReg;
      FMT_DATA16: memWrData = {8'h00, shiftReg[15:0]};
      FMT_HIGH8:  memWrData = {8'h00, shiftReg[7:0], 8'h00};
      default:    memWrData = {16'h0000, shiftReg[7:0]};
    endcase
  end

  assign extDataOut = shiftReg[WORD_W-1:WORD_W-8];
  assign extAddr    = extPtr;
  assign memAddr    = intAddr;
  assign statCount  = wordCnt;
  assign lastWord   = (wordCnt == {{(CNT_W-1){1'b0}}, 1'b1});

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.startXfer && $past(busy)) |-> (wordCnt <= $past(wordCnt)));

  // R11
  busy_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgWrEn && cfgSel == SEL_MODE) |=> ($stable(fmt) && $stable(dirStore)));
endmodule

// File: rtl/byteDmaCtrl.sv
module byteDmaCtrl
  import byteDmaPkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  byteFmtT           fmt,
  input  logic              dirStore,
  input  logic [WAIT_W-1:0] waitCfg,
  input  logic              lastWord,
  input  logic              cpuExtAccess,
  output dmaCtlT            ctl,
  output logic              busy,
  output logic              extReq,
  output logic              extRd,
  output logic              extWr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic              doneIrq
);
  timeunit 1ns;
  timeprecision 10ps;

  dmaStateT          state, nxtState;
  logic [WAIT_W-1:0] waitCnt;
  logic [1:0]        byteLeft;
  logic              finish;
  logic              byteDone;
  logic              wordStart;

  assign byteDone = (state == ST_ACCESS) && (waitCnt == '0);

  always_comb begin
    ctl       = '0;
    nxtState  = state;
    finish    = 1'b0;
    wordStart = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.startXfer = 1'b1;
          ctl.clrShift  = 1'b1;
          wordStart     = 1'b1;
          nxtState      = dirStore ? ST_FETCH : ST_ARB;
        end
      end
      ST_FETCH: nxtState = ST_LATCH;
      ST_LATCH: begin
        ctl.loadOut = 1'b1;
        ctl.incInt  = 1'b1;
        nxtState    = ST_ARB;
      end
      ST_ARB: begin
        if (!cpuExtAccess) nxtState = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (byteDone) begin
          ctl.incExt = 1'b1;
          if (dirStore) ctl.shiftOut = 1'b1;
          else          ctl.shiftIn  = 1'b1;
          if (byteLeft != 2'd0) begin
            nxtState = ST_ARB;
          end else if (!dirStore) begin
            nxtState = ST_COMMIT;
          end else begin
            ctl.decCount = 1'b1;
            if (lastWord) begin
              nxtState = ST_IDLE;
              finish   = 1'b1;
            end else begin
              nxtState  = ST_FETCH;
              wordStart = 1'b1;
            end
          end
        end
      end
      ST_COMMIT: begin
        ctl.incInt   = 1'b1;
        ctl.decCount = 1'b1;
        ctl.clrShift = 1'b1;
        if (lastWord) begin
          nxtState = ST_IDLE;
          finish   = 1'b1;
        end else begin
          nxtState  = ST_ARB;
          wordStart = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      byteLeft <= '0;
      doneIrq  <= 1'b0;
    end else begin
      state   <= nxtState;
      doneIrq <= finish;
      if (state != ST_ACCESS && nxtState == ST_ACCESS) waitCnt <= waitCfg;
      else if (state == ST_ACCESS && waitCnt != '0)     waitCnt <= waitCnt - 1'b1;
      if (wordStart)                          byteLeft <= bytesLess1(fmt);
      else if (byteDone && byteLeft != 2'd0)  byteLeft <= byteLeft - 1'b1;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign extReq  = (state == ST_ARB) || (state == ST_ACCESS);
  assign extRd   = (state == ST_ACCESS) && !dirStore;
  assign extWr   = (state == ST_ACCESS) && dirStore;
  assign memRdEn = (state == ST_FETCH);
  assign memWrEn = (state == ST_COMMIT);

  // R8
  cpu_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARB && cpuExtAccess) |=> !(extRd || extWr));

  // R9
  one_resource_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({extRd, extWr, memRdEn, memWrEn}));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);
endmodule

// File: rtl/byteDmaEngine.sv
module byteDmaEngine
  import byteDmaPkg::*;
#(
  parameter int INT_AW = 14,
  parameter int OFF_W  = 14,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 14,
  parameter int WAIT_W = 3,
  parameter int CFG_W  = 14,
  localparam int EXT_W = OFF_W + PAGE_W,
  localparam int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CNT_W-1:0]  statCount,
  output logic              busy,
  output logic              doneIrq,
  input  logic              cpuExtAccess,
  output logic              extReq,
  output logic [EXT_W-1:0]  extAddr,
  output logic              extRd,
  output logic              extWr,
  input  logic [7:0]        extDataIn,
  output logic [7:0]        extDataOut,
  output logic              extDataOe,
  output logic [INT_AW-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic              memIsProg,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData
);
  timeunit 1ns;
  timeprecision 10ps;

  dmaCtlT            ctl;
  byteFmtT           fmt;
  logic              dirStore;
  logic              startReq;
  logic              lastWord;
  logic [WAIT_W-1:0] waitCfg;

  byteDmaData #(
    .INT_AW(INT_AW), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
    .CNT_W(CNT_W), .WAIT_W(WAIT_W), .CFG_W(CFG_W)
  ) uData (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .busy(busy), .ctl(ctl), .extDataIn(extDataIn),
    .memRdData(memRdData), .startReq(startReq), .fmt(fmt),
    .dirStore(dirStore), .waitCfg(waitCfg), .lastWord(lastWord),
    .extAddr(extAddr), .extDataOut(extDataOut), .memAddr(memAddr),
    .memWrData(memWrData), .statCount(statCount)
  );

  byteDmaCtrl #(.WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fmt(fmt),
    .dirStore(dirStore), .waitCfg(waitCfg), .lastWord(lastWord),
    .cpuExtAccess(cpuExtAccess), .ctl(ctl), .busy(busy), .extReq(extReq),
    .extRd(extRd), .extWr(extWr), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .doneIrq(doneIrq)
  );

  assign extDataOe = extWr;
  assign memIsProg = (fmt == FMT_PROG24);

  // R7
  done_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (statCount == '0 && !busy));

  // R2
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && fmt != FMT_PROG24) |-> (memWrData[WORD_W-1:WORD_W-8] == 8'h00));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((extRd || extWr) && $past(extRd || extWr)) |-> $stable(extAddr));
endmodule

// File: tb/sim_byteDmaEngine.sv
module sim_byteDmaEngine;
  timeunit 1ns;
  timeprecision 10ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = 3'd0;
  logic [13:0] cfgWrData = 14'd0;
  logic [13:0] statCount;
  logic        busy, doneIrq, extReq, extRd, extWr, extDataOe;
  logic        cpuExtAccess = 1'b0;
  logic [21:0] extAddr;
  logic [7:0]  extDataIn, extDataOut;
  logic [13:0] memAddr;
  logic        memRdEn, memWrEn, memIsProg;
  logic [23:0] memWrData;
  logic [23:0] memRdData = 24'h0;

  always #2 clk = ~clk;

  byteDmaEngine u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .statCount(statCount), .busy(busy),
    .doneIrq(doneIrq), .cpuExtAccess(cpuExtAccess), .extReq(extReq),
    .extAddr(extAddr), .extRd(extRd), .extWr(extWr), .extDataIn(extDataIn),
    .extDataOut(extDataOut), .extDataOe(extDataOe), .memAddr(memAddr),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memIsProg(memIsProg),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  function automatic logic [7:0] byteAt(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ a[21:14] ^ 8'h5A;
  endfunction
  function automatic logic [23:0] wordAt(input logic [13:0] a);
    return {a[7:0] ^ 8'hC3, a[13:6] ^ 8'h96, ~a[7:0]};
  endfunction
  function automatic logic [23:0] mapLoad(input logic [23:0] w, input int f);
    case (f)
      0: return w;
      1: return {8'h00, w[15:0]};
      2: return {8'h00, w[7:0], 8'h00};
      default: return {16'h0000, w[7:0]};
    endcase
  endfunction
  function automatic logic [7:0] storeByte(input logic [23:0] s, input int f, input int b);
    case (f)
      0: return (b == 0) ? s[23:16] : (b == 1) ? s[15:8] : s[7:0];
      1: return (b == 0) ? s[15:8] : s[7:0];
      2: return s[15:8];
      default: return s[7:0];
    endcase
  endfunction

  assign extDataIn = byteAt(extAddr);
  always @(posedge clk) memRdData <= memRdEn ? wordAt(memAddr) : 24'h0;

  int nChecks = 0;
  int nErrors = 0;
  bit chkOn = 1'b0;
  bit cpuMode = 1'b0;
  bit ended = 1'b0;

  logic        eBusy = 0, eReq = 0, eRd = 0, eWr = 0, eMemRd = 0, eMemWr = 0, eIrq = 0, eProg = 0;
  logic [21:0] eAddr = 0;
  logic [7:0]  eData = 0;
  logic [13:0] eMemAddr = 0;
  logic [23:0] eMemData = 0;
  logic [13:0] eCount = 0;
  int          mCnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      chk(busy === eBusy, "R5", "busy", 32'(busy), 32'(eBusy));
      chk(statCount === eCount, "R5", "statCount", 32'(statCount), 32'(eCount));
      chk(doneIrq === eIrq, "R7", "doneIrq", 32'(doneIrq), 32'(eIrq));
      chk(extReq === eReq, "R8", "extReq", 32'(extReq), 32'(eReq));
      chk(extRd === eRd, "R6", "extRd", 32'(extRd), 32'(eRd));
      chk(extWr === eWr, "R10", "extWr", 32'(extWr), 32'(eWr));
      chk(extDataOe === eWr, "R10", "extDataOe", 32'(extDataOe), 32'(eWr));
      chk(memRdEn === eMemRd, "R9", "memRdEn", 32'(memRdEn), 32'(eMemRd));
      chk(memWrEn === eMemWr, "R9", "memWrEn", 32'(memWrEn), 32'(eMemWr));
      if (eRd || eWr) chk(extAddr === eAddr, "R3", "extAddr", 32'(extAddr), 32'(eAddr));
      if (eWr) chk(extDataOut === eData, "R1", "extDataOut", 32'(extDataOut), 32'(eData));
      if (eMemRd || eMemWr) begin
        chk(memAddr === eMemAddr, "R4", "memAddr", 32'(memAddr), 32'(eMemAddr));
        chk(memIsProg === eProg, "R1", "memIsProg", 32'(memIsProg), 32'(eProg));
      end
      if (eMemWr) chk(memWrData === eMemData, "R2", "memWrData", 32'(memWrData), 32'(eMemData));
    end
  end

  // Processor bus traffic, changed just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #0.5;
      cpuExtAccess = cpuMode ? (($urandom % 3) == 0) : 1'b0;
    end
  end

  task automatic nextCycle();
    @(posedge clk);
    #0.2;
    eBusy = 1; eReq = 0; eRd = 0; eWr = 0; eMemRd = 0; eMemWr = 0; eIrq = 0;
    eCount = 14'(mCnt);
  endtask

  // Behavioural reference: one transfer, cycle by cycle
  task automatic modelRun(input int nWords, input int f, input bit dir, input int w,
                          input logic [13:0] ia0, input logic [21:0] p0);
    logic [13:0] ia = ia0;
    logic [21:0] p = p0;
    int nb = (f == 0) ? 3 : (f == 1) ? 2 : 1;
    mCnt = nWords;
    for (int wd = 0; wd < nWords; wd++) begin
      logic [23:0] word = 24'h0;
      logic [23:0] src = 24'h0;
      if (dir) begin
        nextCycle(); eMemRd = 1; eMemAddr = ia;
        src = wordAt(ia);
        ia++;
        nextCycle();
      end
      for (int b = 0; b < nb; b++) begin
        bit waiting;
        do begin
          nextCycle(); eReq = 1;
          #0.8;
          waiting = cpuExtAccess;
        end while (waiting);
        for (int k = 0; k <= w; k++) begin
          nextCycle(); eReq = 1; eAddr = p;
          if (dir) begin eWr = 1; eData = storeByte(src, f, b); end
          else eRd = 1;
        end
        if (!dir) word = {word[15:0], byteAt(p)};
        p++;
      end
      if (!dir) begin
        nextCycle(); eMemWr = 1; eMemAddr = ia; eMemData = mapLoad(word, f);
        ia++;
      end
      mCnt--;
    end
    nextCycle(); eBusy = 0; eIrq = 1;
    nextCycle(); eBusy = 0;
  endtask

  task automatic cfgWr(input logic [2:0] sel, input logic [13:0] data);
    @(posedge clk);
    #0.5;
    cfgWrEn = 1; cfgSel = sel; cfgWrData = data;
    @(posedge clk);
    #0.5;
    cfgWrEn = 0;
  endtask

  task automatic runXfer(input int nWords, input int f, input bit dir, input int w,
                         input logic [13:0] ia, input logic [7:0] page,
                         input logic [13:0] off, input bit cpuOn, input bit inject);
    cpuMode = cpuOn;
    cfgWr(3'd0, ia);
    cfgWr(3'd1, off);
    cfgWr(3'd2, {6'd0, page});
    cfgWr(3'd3, 14'((f << 1) | int'(dir)));
    cfgWr(3'd4, 14'(w));
    eProg = (f == 0);
    @(posedge clk);
    #0.5;
    cfgWrEn = 1; cfgSel = 3'd5; cfgWrData = 14'(nWords);
    fork
      modelRun(nWords, f, dir, w, ia, {page, off});
      begin
        @(posedge clk);
        #0.5;
        cfgWrEn = 0;
        if (inject) begin
          // R11: count, page and wait writes mid-transfer must be ignored
          repeat (6) @(posedge clk);
          #0.5; cfgWrEn = 1; cfgSel = 3'd5; cfgWrData = 14'd9;
          @(posedge clk);
          #0.5; cfgSel = 3'd2; cfgWrData = 14'h33;
          @(posedge clk);
          #0.5; cfgSel = 3'd4; cfgWrData = 14'd0;
          @(posedge clk);
          #0.5; cfgSel = 3'd3; cfgWrData = 14'd1;
          @(posedge clk);
          #0.5; cfgWrEn = 0;
        end
      end
    join
    cpuMode = 0;
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL R5 watchdog: actual still running expected finished");
    finishRun();
  end

  initial begin
    // R12: idle outputs during and right after reset
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && extRd === 1'b0 && extWr === 1'b0 && memWrEn === 1'b0,
        "R12", "strobes in reset", 32'({busy, extRd, extWr, memWrEn}), 32'd0);
    chk(statCount === 14'd0, "R12", "count in reset", 32'(statCount), 32'd0);
    @(posedge clk);
    #0.5;
    rstN = 1;
    chkOn = 1;
    repeat (3) @(posedge clk);

    // R1 R4 R6: program words, no wait states
    runXfer(3, 0, 1'b0, 0, 14'h010, 8'h02, 14'h0100, 1'b0, 1'b0);
    // R2 R8: 16-bit loads with wait states under bus contention
    runXfer(4, 1, 1'b0, 2, 14'h200, 8'h07, 14'h1234, 1'b1, 1'b0);
    // R2: single byte into the upper and lower halves
    runXfer(2, 2, 1'b0, 1, 14'h3F0, 8'h11, 14'h0040, 1'b0, 1'b0);
    runXfer(2, 3, 1'b0, 0, 14'h3F8, 8'h12, 14'h0050, 1'b1, 1'b0);
    // R10 R1: stores in every format
    runXfer(2, 0, 1'b1, 1, 14'h055, 8'h20, 14'h0300, 1'b1, 1'b0);
    runXfer(3, 1, 1'b1, 0, 14'h066, 8'h21, 14'h0400, 1'b0, 1'b0);
    runXfer(2, 2, 1'b1, 2, 14'h077, 8'h22, 14'h0500, 1'b1, 1'b0);
    runXfer(2, 3, 1'b1, 0, 14'h088, 8'h23, 14'h0600, 1'b0, 1'b0);
    // R3: offset carries into the page, and the top of the space wraps
    runXfer(2, 0, 1'b0, 0, 14'h100, 8'h05, 14'h3FFE, 1'b0, 1'b0);
    runXfer(2, 1, 1'b1, 1, 14'h120, 8'hFF, 14'h3FFE, 1'b1, 1'b0);
    // R11: writes while busy
    runXfer(5, 1, 1'b0, 3, 14'h140, 8'h30, 14'h0700, 1'b1, 1'b1);
    // R5: zero count starts nothing
    cfgWr(3'd5, 14'd0);
    repeat (4) @(posedge clk);
    // R7 R9: one-word transfer ends cleanly
    runXfer(1, 3, 1'b0, 0, 14'h3FFF, 8'h01, 14'h0001, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule